// File: doc/BRIEF.md
# EEPROM Access Control Sequencer

This block sits on a small CPU's I/O bus and controls a byte-wide on-chip data EEPROM. It has three registers: a 4-bit control register, an address register and a data register. The control register has four bits: a ready-interrupt enable, a self-clearing arm bit, a write strobe that also serves as the busy flag, and a read strobe. The storage is a synthesizable byte array that powers up erased, with every byte at 0xFF.

A read copies the addressed byte into the data register at once. A write is accepted only when the arm bit is still live, which lasts four cycles after software sets it. The write then runs for a parameterized number of programming cycles and commits its byte at the end. Each accepted access raises a CPU stall request for a fixed number of cycles. A level-sensitive ready interrupt stays high while no write is in progress.

Software may load the address and data registers and set the arm bit in any order. The block latches the address and data when a write starts, so later register writes cannot disturb the byte being programmed.

Top module: `eec_top`

## Requirements
- R1: The control register sits at I/O offset 0x1C. Bit 3 is the interrupt enable, bit 2 is arm, bit 1 is the write strobe/busy flag and bit 0 is the read strobe. Bits 7..4 always read zero and ignore writes.
- R2: After reset, all control bits, the address register and the data register are zero, the stall request is low, and every storage byte reads 0xFF.
- R3: Writing 1 to bit 2 sets arm. Arm then reads one for exactly four cycles and is cleared by hardware. Writing 0 to bit 2 does not clear it.
- R4: A write of 1 to bit 1 starts a write only if arm is one before that access. Otherwise it has no effect: bit 1 stays zero, there is no stall and the storage is unchanged. One access that sets bits 2 and 1 together only arms.
- R5: An accepted write holds bit 1 at one for WRITE_CYCLES cycles, after which hardware clears it. At that point the storage byte at the latched address holds the latched data.
- R6: An accepted write clears arm in the same cycle.
- R7: The stall request is high for two cycles after an accepted write and for four cycles after a read.
- R8: A write of 1 to bit 0 loads the data register (offset 0x1D) from the storage byte selected by the address register. Bit 0 then reads one during the four stall cycles and zero afterwards.
- R9: While a write is in progress, read and write strobes are ignored: no stall, the data register is unchanged and no second write starts. Writes to the address and data registers during that time do not change the byte being programmed.
- R10: The ready interrupt equals interrupt enable AND the global interrupt flag AND NOT busy, as a level.
- R11: If one access sets bits 1 and 0 and the write is accepted, the read is dropped. If the write is not accepted, the read proceeds.
- R12: The address register sits at offset 0x1E and keeps only the low log2(DEPTH) bits. The upper bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | 6 | I/O register offset for reads and writes |
| io_we | input | 1 | I/O write strobe for one cycle |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | Combinational read data for io_addr |
| glob_ie | input | 1 | CPU global interrupt flag |
| stall_req | output | 1 | CPU stall request |
| rdy_irq | output | 1 | Level ready interrupt |

## Verification
The hardest cases to reach are the edges of the arm window. The strobe must arrive exactly on the fourth cycle after arming, and a second case must miss it by one cycle. The bench drives the I/O bus at falling edges with back-to-back accesses and a counted number of idle cycles, so each strobe lands on a known cycle. A second hard case is the long busy interval. The bench reads the busy bit one cycle before and exactly at the end of the programming time. During that interval it rewrites the address and data registers and fires stray read and write strobes. It then reads back both the intended location and the decoy location.

// File: rtl/eec_pkg.sv
`timescale 1ns/1ps
// Package eec_pkg: shared offsets, bit positions and timing constants for the
// EEPROM access sequencer. Assumes a 6-bit I/O offset space.
package eec_pkg;
    localparam int IO_AW = 6;
    localparam logic [IO_AW-1:0] IOA_CTRL = 6'h1C;
    localparam logic [IO_AW-1:0] IOA_DATA = 6'h1D;
    localparam logic [IO_AW-1:0] IOA_ADDR = 6'h1E;

    localparam int BIT_IE  = 3;
    localparam int BIT_ARM = 2;
    localparam int BIT_WR  = 1;
    localparam int BIT_RD  = 0;

    localparam int ARM_WINDOW = 4;
    localparam int STALL_WR   = 2;
    localparam int STALL_RD   = 4;

    typedef struct packed {
        logic [3:0] rsvd;
        logic       ie;
        logic       arm;
        logic       wr_busy;
        logic       rd_act;
    } ctrl_view_t;
endpackage

// File: rtl/eec_arm_window.sv
`timescale 1ns/1ps
// Module eec_arm_window: arm bit with a hardware timeout. A set loads the
// window count; arm reads one while the count is nonzero. A kill clears it at
// once and has priority over a set. Assumes WIN >= 1.
module eec_arm_window #(
    parameter int WIN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_set,
    input  logic arm_kill,
    output logic armed
);
    localparam int CW = $clog2(WIN + 1);

    logic [CW-1:0] cnt_q;

    // Load, count down or kill the arm window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (arm_kill) begin
            cnt_q <= '0;
        end else if (arm_set) begin
            cnt_q <= CW'(WIN);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign armed = (cnt_q != '0);

    AST_ARM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(WIN)); // R3

    AST_ARM_KILL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        arm_kill |=> !armed); // R6
endmodule

// File: rtl/eec_write_timer.sv
`timescale 1ns/1ps
// Module eec_write_timer: programming-time counter. A start loads CYCLES;
// busy is high while the count is nonzero. done pulses in the last busy
// cycle, so the commit edge is the edge where busy falls. Starts while busy
// are assumed to be blocked by the caller.
module eec_write_timer #(
    parameter int CYCLES = 8160
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int TW = $clog2(CYCLES + 1);

    logic [TW-1:0] cnt_q;

    // Count the programming interval down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start && cnt_q == '0) begin
            cnt_q <= TW'(CYCLES);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy = (cnt_q != '0);
    assign done = (cnt_q == TW'(1));

    AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= TW'(CYCLES)); // R5

    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy); // R5
endmodule

// File: rtl/eec_stall_gen.sv
`timescale 1ns/1ps
// Module eec_stall_gen: CPU stall request of fixed length per access kind.
// Also reports whether the current stall belongs to a read, which drives the
// read-strobe readback. Assumes ld_wr and ld_rd are never high together.
module eec_stall_gen #(
    parameter int WR_LEN = 2,
    parameter int RD_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ld_wr,
    input  logic ld_rd,
    output logic stall,
    output logic rd_active
);
    localparam int MAXL = (WR_LEN > RD_LEN) ? WR_LEN : RD_LEN;
    localparam int SW   = $clog2(MAXL + 1);

    logic [SW-1:0] cnt_q;
    logic          rd_mode_q;

    // Load the stall length for the access kind and count it down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            rd_mode_q <= 1'b0;
        end else if (ld_wr) begin
            cnt_q     <= SW'(WR_LEN);
            rd_mode_q <= 1'b0;
        end else if (ld_rd) begin
            cnt_q     <= SW'(RD_LEN);
            rd_mode_q <= 1'b1;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign stall     = (cnt_q != '0);
    assign rd_active = stall && rd_mode_q;

    AST_STALL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= SW'(MAXL)); // R7

    AST_LOAD_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(ld_wr && ld_rd)); // R11
endmodule

// File: rtl/eec_store.sv
`timescale 1ns/1ps
// Module eec_store: byte storage array, erased to 0xFF on reset. One
// synchronous write port and one combinational read port. Assumes DEPTH is a
// power of two.
module eec_store #(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem_q [DEPTH];

    // One update process per row: erase on reset, otherwise take the commit.
    for (genvar g = 0; g < DEPTH; g++) begin : g_row
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem_q[g] <= 8'hFF;
            end else if (we && waddr == AW'(g)) begin
                mem_q[g] <= wdata;
            end
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/eec_top.sv
`timescale 1ns/1ps
// Module eec_top: EEPROM access control sequencer on a CPU I/O bus. It decodes
// the control, address and data registers, gates writes through the arm
// window, latches address and data when a write starts, and drives the stall
// request and ready interrupt. Assumes at most one I/O write per cycle and
// DEPTH <= 256.
module eec_top
    import eec_pkg::*;
#(
    parameter int DEPTH        = 64,
    parameter int WRITE_CYCLES = 8160
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IO_AW-1:0] io_addr,
    input  logic             io_we,
    input  logic [7:0]       io_wdata,
    output logic [7:0]       io_rdata,
    input  logic             glob_ie,
    output logic             stall_req,
    output logic             rdy_irq
);
    localparam int AW = $clog2(DEPTH);

    logic          ie_q;
    logic [AW-1:0] addr_q;
    logic [7:0]    data_q;
    logic [AW-1:0] lat_addr_q;
    logic [7:0]    lat_data_q;

    logic       ctrl_hit, wr_req, rd_req, wr_go, rd_go, arm_set;
    logic       armed, busy, commit, rd_active;
    logic [7:0] store_rdata;
    ctrl_view_t ctrl_view;

    // Decode control-register accesses into arm, write and read requests.
    always_comb begin
        ctrl_hit = io_we && (io_addr == IOA_CTRL);
        arm_set  = ctrl_hit && io_wdata[BIT_ARM];
        wr_req   = ctrl_hit && io_wdata[BIT_WR];
        rd_req   = ctrl_hit && io_wdata[BIT_RD];
        wr_go    = wr_req && armed && !busy;
        rd_go    = rd_req && !busy && !wr_go;
    end

    eec_arm_window #(.WIN(ARM_WINDOW)) u_arm (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm_set  (arm_set),
        .arm_kill (wr_go),
        .armed    (armed)
    );

    eec_write_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (wr_go),
        .busy  (busy),
        .done  (commit)
    );

    eec_stall_gen #(.WR_LEN(STALL_WR), .RD_LEN(STALL_RD)) u_stall (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_wr     (wr_go),
        .ld_rd     (rd_go),
        .stall     (stall_req),
        .rd_active (rd_active)
    );

    eec_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (commit),
        .waddr (lat_addr_q),
        .wdata (lat_data_q),
        .raddr (addr_q),
        .rdata (store_rdata)
    );

    // Interrupt enable follows every control-register write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q <= 1'b0;
        end else if (ctrl_hit) begin
            ie_q <= io_wdata[BIT_IE];
        end
    end

    // Address register: software writes keep the low AW bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (io_we && io_addr == IOA_ADDR) begin
            addr_q <= io_wdata[AW-1:0];
        end
    end

    // Data register: software writes, or loaded from storage by a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (rd_go) begin
            data_q <= store_rdata;
        end else if (io_we && io_addr == IOA_DATA) begin
            data_q <= io_wdata;
        end
    end

    // Capture the target address and byte when a write is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_addr_q <= '0;
            lat_data_q <= '0;
        end else if (wr_go) begin
            lat_addr_q <= addr_q;
            lat_data_q <= data_q;
        end
    end

    // Assemble the control-register readback.
    always_comb begin
        ctrl_view         = '0;
        ctrl_view.ie      = ie_q;
        ctrl_view.arm     = armed;
        ctrl_view.wr_busy = busy;
        ctrl_view.rd_act  = rd_active;
    end

    // I/O read multiplexer.
    always_comb begin
        unique case (io_addr)
            IOA_CTRL: io_rdata = ctrl_view;
            IOA_DATA: io_rdata = data_q;
            IOA_ADDR: io_rdata = 8'(addr_q);
            default:  io_rdata = 8'h00;
        endcase
    end

    assign rdy_irq = ie_q && glob_ie && !busy;

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (io_addr == IOA_CTRL) |-> (io_rdata[7:4] == 4'h0)); // R1

    AST_WRITE_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(armed)); // R4

    AST_ACCEPT_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !armed); // R6

    AST_WRITE_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> stall_req); // R7

    AST_LATCH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(lat_addr_q) && $stable(lat_data_q))); // R9

    AST_IRQ_QUIET_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !rdy_irq); // R10
endmodule

// File: tb/eec_top_tb.sv
`timescale 1ns/1ps
// Bench eec_top_tb_top: the driver task pushes expected values into a
// scoreboard queue; the monitor process pops them and compares each against
// the design's outputs.
module eec_top_tb_top;
    localparam logic [5:0] A_CTRL = 6'h1C;
    localparam logic [5:0] A_DATA = 6'h1D;
    localparam logic [5:0] A_ADDR = 6'h1E;
    localparam int WCYC = 8160;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] io_addr = '0;
    logic       io_we = 1'b0;
    logic [7:0] io_wdata = '0;
    logic [7:0] io_rdata;
    logic       glob_ie = 1'b0;
    logic       stall_req;
    logic       rdy_irq;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    typedef struct {
        int         kind;
        logic [7:0] mask;
        logic [7:0] exp;
        string      tag;
    } sb_item_t;

    sb_item_t sbq[$];
    event     mon_ev;

    always #2.5 clk = ~clk;

    eec_top #(.DEPTH(64), .WRITE_CYCLES(WCYC)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .io_addr   (io_addr),
        .io_we     (io_we),
        .io_wdata  (io_wdata),
        .io_rdata  (io_rdata),
        .glob_ie   (glob_ie),
        .stall_req (stall_req),
        .rdy_irq   (rdy_irq)
    );

    // Monitor: pop each expected item and compare it with the live output.
    initial begin
        forever begin
            @(mon_ev);
            while (sbq.size() > 0) begin
                sb_item_t it;
                logic [7:0] act;
                it = sbq.pop_front();
                case (it.kind)
                    0:       act = io_rdata;
                    1:       act = {7'd0, stall_req};
                    default: act = {7'd0, rdy_irq};
                endcase
                n_chk++;
                if ((act & it.mask) !== (it.exp & it.mask)) begin
                    n_fail++;
                    $display("FAIL %s: actual %02h expected %02h", it.tag,
                             act & it.mask, it.exp & it.mask);
                end
            end
        end
    end

    task automatic io_write(input logic [5:0] a, input logic [7:0] d);
        io_addr  = a;
        io_wdata = d;
        io_we    = 1'b1;
        @(negedge clk);
        io_we    = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic exp_reg(input logic [5:0] a, input logic [7:0] m,
                           input logic [7:0] e, input string tag);
        sb_item_t it;
        io_addr = a;
        #0.1;
        it.kind = 0; it.mask = m; it.exp = e; it.tag = tag;
        sbq.push_back(it);
        ->mon_ev;
        #0.1;
    endtask

    task automatic exp_pin(input int kind, input logic e, input string tag);
        sb_item_t it;
        it.kind = kind; it.mask = 8'h01; it.exp = {7'd0, e}; it.tag = tag;
        sbq.push_back(it);
        ->mon_ev;
        #0.2;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R5 watchdog: actual hang expected completion");
            finish_run();
        end
    end

    // Stimulus.
    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R2 reset state
        exp_reg(A_CTRL, 8'hFF, 8'h00, "R2 ctrl reset");
        exp_reg(A_ADDR, 8'hFF, 8'h00, "R2 addr reset");
        exp_reg(A_DATA, 8'hFF, 8'h00, "R2 data reset");
        exp_pin(1, 1'b0, "R2 stall reset");
        exp_pin(2, 1'b0, "R2 irq reset");

        // R1 reserved bits, R12 address width
        io_write(A_CTRL, 8'hF0);
        exp_reg(A_CTRL, 8'hFF, 8'h00, "R1 reserved ignore");
        io_write(A_ADDR, 8'hFF);
        exp_reg(A_ADDR, 8'hFF, 8'h3F, "R12 addr low bits");
        io_write(A_DATA, 8'h5A);
        exp_reg(A_DATA, 8'hFF, 8'h5A, "R8 data reg write");

        // R8 read of erased byte, R2 erased value
        io_write(A_ADDR, 8'h05);
        io_write(A_CTRL, 8'h01);
        exp_reg(A_DATA, 8'hFF, 8'hFF, "R2 erased byte");
        exp_reg(A_CTRL, 8'hFF, 8'h01, "R8 rd bit set");
        exp_pin(1, 1'b1, "R7 read stall start");
        idle(3);
        exp_pin(1, 1'b1, "R7 read stall 4th");
        exp_reg(A_CTRL, 8'h01, 8'h01, "R8 rd bit 4th");
        idle(1);
        exp_pin(1, 1'b0, "R7 read stall end");
        exp_reg(A_CTRL, 8'hFF, 8'h00, "R8 rd bit clear");

        // R3 arm window
        io_write(A_CTRL, 8'h04);
        exp_reg(A_CTRL, 8'hFF, 8'h04, "R3 arm set");
        io_write(A_CTRL, 8'h00);
        exp_reg(A_CTRL, 8'hFF, 8'h04, "R3 write zero keeps arm");
        idle(2);
        exp_reg(A_CTRL, 8'hFF, 8'h04, "R3 arm 4th cycle");
        idle(1);
        exp_reg(A_CTRL, 8'hFF, 8'h00, "R3 arm expired");

        // R4 late strobe rejected
        io_write(A_DATA, 8'h5A);
        io_write(A_CTRL, 8'h04);
        idle(4);
        io_write(A_CTRL, 8'h02);
        exp_reg(A_CTRL, 8'hFF, 8'h00, "R4 late strobe no busy");
        exp_pin(1, 1'b0, "R4 late strobe no stall");
        // R4 arm and strobe in one access only arms
        io_write(A_CTRL, 8'h06);
        exp_reg(A_CTRL, 8'hFF, 8'h04, "R4 combined only arms");
        exp_pin(1, 1'b0, "R4 combined no stall");
        idle(4);
        io_write(A_CTRL, 8'h01);
        exp_reg(A_DATA, 8'hFF, 8'hFF, "R4 storage unchanged");
        idle(4);

        // R5/R6/R7/R9/R10 accepted write on the 4th window cycle
        glob_ie = 1'b1;
        io_write(A_ADDR, 8'h05);
        io_write(A_DATA, 8'h3C);
        io_write(A_CTRL, 8'h0C);
        exp_pin(2, 1'b1, "R10 irq idle");
        idle(3);
        io_write(A_CTRL, 8'h0A);                       // n = 0
        exp_reg(A_CTRL, 8'hFF, 8'h0A, "R6 busy set arm cleared");
        exp_pin(1, 1'b1, "R7 write stall start");
        exp_pin(2, 1'b0, "R10 irq low busy");
        idle(1);                                       // n = 1
        exp_pin(1, 1'b1, "R7 write stall 2nd");
        idle(1);                                       // n = 2
        exp_pin(1, 1'b0, "R7 write stall end");
        io_write(A_ADDR, 8'h07);                       // n = 3
        io_write(A_DATA, 8'h11);                       // n = 4
        io_write(A_CTRL, 8'h09);                       // n = 5
        exp_reg(A_DATA, 8'hFF, 8'h11, "R9 read ignored data");
        exp_pin(1, 1'b0, "R9 read ignored stall");
        exp_reg(A_CTRL, 8'hFF, 8'h0A, "R9 rd bit stays low");
        io_write(A_CTRL, 8'h0C);                       // n = 6
        io_write(A_CTRL, 8'h0A);                       // n = 7
        exp_pin(1, 1'b0, "R9 second write ignored");
        idle(WCYC - 8);                                // n = WCYC-1
        exp_reg(A_CTRL, 8'h02, 8'h02, "R5 busy last cycle");
        exp_pin(2, 1'b0, "R10 irq low last cycle");
        idle(1);                                       // n = WCYC
        exp_reg(A_CTRL, 8'h02, 8'h00, "R5 busy cleared");
        exp_pin(2, 1'b1, "R10 irq back");
        glob_ie = 1'b0;
        #0.1;
        exp_pin(2, 1'b0, "R10 global flag gates irq");
        io_write(A_CTRL, 8'h01);
        exp_reg(A_DATA, 8'hFF, 8'hFF, "R9 decoy address untouched");
        idle(4);
        io_write(A_ADDR, 8'h05);
        io_write(A_CTRL, 8'h01);
        exp_reg(A_DATA, 8'hFF, 8'h3C, "R5 byte committed");
        idle(4);

        // R11 both strobes with arm: write wins
        io_write(A_ADDR, 8'h09);
        io_write(A_DATA, 8'h77);
        io_write(A_CTRL, 8'h04);
        io_write(A_CTRL, 8'h03);
        exp_reg(A_CTRL, 8'hFF, 8'h02, "R11 write wins");
        exp_pin(1, 1'b1, "R11 stall 1");
        idle(2);
        exp_pin(1, 1'b0, "R11 stall only two");
        idle(WCYC);
        io_write(A_CTRL, 8'h01);
        exp_reg(A_DATA, 8'hFF, 8'h77, "R11 write committed");
        idle(4);
        // R11 both strobes without arm: read proceeds
        io_write(A_ADDR, 8'h05);
        io_write(A_DATA, 8'h99);
        io_write(A_CTRL, 8'h03);
        exp_reg(A_CTRL, 8'hFF, 8'h01, "R11 read proceeds");
        exp_reg(A_DATA, 8'hFF, 8'h3C, "R11 read data");
        idle(4);
        exp_reg(A_CTRL, 8'hFF, 8'h00, "R11 no write started");

        done = 1'b1;
        #1;
        finish_run();
    end
endmodule